// File: doc/BRIEF.md
# Cached-Top Data Stack

This block is the operand stack of a small stack processor. The two newest entries live in flip-flops: the top in register A and the entry below it in register B. Both feed the arithmetic unit directly. Every older entry sits in a small memory that has one asynchronous read port and one separate write port. A write pointer counts how many entries are in that memory. Because a spill and a fill use different ports, each operation finishes at a single clock edge. This holds for a push, drop, dup, swap, or a binary operation that takes two operands and leaves one result.

A sequencer issues one operation per cycle. It drives `valid_i`, a 4-bit opcode and, for a push, a data word. The top of the stack is always visible on `tos_o`. An operation the stack cannot carry out is refused and leaves the stack untouched. A refused operation raises `overflow_o` or `underflow_o` for exactly one cycle, starting at the edge that would have performed it. Entries only ever move by one position per operation.

The control is a four-state fill machine. `ST_EMPTY` holds no entries. `ST_ONE` holds only A. `ST_TWO` holds A and B with the memory empty. `ST_DEEP` holds A, B and between 1 and `MEM_DEPTH` memory entries. The transitions are:
- Growing: `ST_EMPTY`→`ST_ONE`→`ST_TWO`→`ST_DEEP`. The machine then stays in `ST_DEEP`, and each further growth raises the pointer by one.
- Shrinking: `ST_DEEP` falls back to `ST_TWO` when the pointer leaves 1. Otherwise the machine stays in `ST_DEEP` and lowers the pointer. After that, shrinking goes `ST_TWO`→`ST_ONE`→`ST_EMPTY`.
- Swap, idle cycles and refused operations keep the current state.

Top module: `stk_cached_top`

## Requirements
- R1: After reset the stack is empty, `tos_o` reads 0, and both flags are low.
- R2: A push (opcode 1) with room left makes `push_data_i` the new top at the next edge. The former top becomes the second entry.
- R3: A drop (opcode 2) on a non-empty stack removes the top. The former second entry becomes the top. When the stack becomes empty, `tos_o` reads 0.
- R4: A dup (opcode 3) on a non-empty stack with room left pushes a copy of the current top.
- R5: A swap (opcode 4) with at least two entries exchanges the top and second entries.
- R6: Binary opcodes 5 to 9 need at least two entries. They replace the top two entries with one result: 5 gives second + top, 6 gives second − top, 7 gives second AND top, 8 gives second OR top, and 9 gives second XOR top, all modulo 2^DATA_W. The entry that was third becomes second at the same edge.
- R7: Every accepted operation completes at the edge where it is presented. Operations may be issued on consecutive cycles without idle cycles between them.
- R8: The stack holds `MEM_DEPTH`+2 entries in last-in, first-out order across the register and memory boundary.
- R9: A push or dup on a full stack is ignored and `overflow_o` is high for exactly the following cycle.
- R10: A drop or dup on an empty stack, or a swap or binary opcode with fewer than two entries, is ignored and `underflow_o` is high for exactly the following cycle.
- R11: A cycle with `valid_i` low, or with opcode 0 or 10 to 15, changes no entry and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| opcode_i | input | 4 | Operation code (see R2 to R6, R11) |
| push_data_i | input | DATA_W | Word pushed by opcode 1 |
| tos_o | output | DATA_W | Current top of stack, 0 when empty |
| overflow_o | output | 1 | One-cycle pulse: push or dup refused on a full stack |
| underflow_o | output | 1 | One-cycle pulse: operation refused for lack of entries |

## Verification
The bench builds the stack with `MEM_DEPTH`=4 and `DATA_W`=8, so the capacity is six entries. With that capacity, every one of the sixteen opcodes can be tried at every fill level from empty to full, and the whole stack can be drained and compared after each attempt. This reaches every state, every transition, both refusal flags, and the memory boundary between `ST_TWO` and `ST_DEEP`. The 8-bit width also allows a wide grid of operand pairs for each binary opcode on a full stack. The expected result of each pair is computed arithmetically, and the refilled third entry is checked afterwards.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam logic [3:0] OPC_NOP  = 4'd0;
    localparam logic [3:0] OPC_PUSH = 4'd1;
    localparam logic [3:0] OPC_DROP = 4'd2;
    localparam logic [3:0] OPC_DUP  = 4'd3;
    localparam logic [3:0] OPC_SWAP = 4'd4;
    localparam logic [3:0] OPC_ADD  = 4'd5;
    localparam logic [3:0] OPC_SUB  = 4'd6;
    localparam logic [3:0] OPC_AND  = 4'd7;
    localparam logic [3:0] OPC_OR   = 4'd8;
    localparam logic [3:0] OPC_XOR  = 4'd9;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_ONE,
        ST_TWO,
        ST_DEEP
    } fill_state_e;

    // What the register pair does at the next edge
    typedef enum logic [2:0] {
        ACT_NONE,   // hold
        ACT_LOAD,   // A <= push data, B <= A
        ACT_COPY,   // B <= A (dup)
        ACT_RAISE,  // A <= B, B <= fill
        ACT_SWAP,   // exchange A and B
        ACT_ALU     // A <= B op A, B <= fill
    } reg_act_e;

    function automatic logic is_binary(input logic [3:0] op);
        return (op >= OPC_ADD) && (op <= OPC_XOR);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] top_i,
    input  logic [DATA_W-1:0] second_i,
    output logic [DATA_W-1:0] result_o
);

    always_comb begin
        case (op_i)
            OPC_ADD: result_o = second_i + top_i;
            OPC_SUB: result_o = second_i - top_i;
            OPC_AND: result_o = second_i & top_i;
            OPC_OR:  result_o = second_i | top_i;
            OPC_XOR: result_o = second_i ^ top_i;
            default: result_o = top_i;
        endcase
    end

endmodule

// File: rtl/stk_spill_mem.sv
module stk_spill_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int MEM_DEPTH = 16,
    localparam int AW       = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
    localparam int SPW      = $clog2(MEM_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_i,
    input  logic [3:0]     opcode_i,
    output reg_act_e       act_o,
    output logic           spill_we_o,
    output logic [AW-1:0]  waddr_o,
    output logic [AW-1:0]  raddr_o,
    output logic           fill_ok_o,
    output logic           full_o,
    output logic           empty_o,
    output logic           overflow_o,
    output logic           underflow_o
);

    fill_state_e     state_q, state_n;
    logic [SPW-1:0]  sp_q, sp_n;
    logic [SPW-1:0]  sp_m1;
    logic            ovf_n, unf_n;
    logic            has_one, has_two;
    logic            grow, shrink;

    assign has_one   = (state_q != ST_EMPTY);
    assign has_two   = (state_q == ST_TWO) || (state_q == ST_DEEP);
    assign full_o    = (state_q == ST_DEEP) && (sp_q == SPW'(MEM_DEPTH));
    assign empty_o   = (state_q == ST_EMPTY);
    assign fill_ok_o = (state_q == ST_DEEP);
    assign sp_m1     = sp_q - SPW'(1);
    assign waddr_o   = sp_q[AW-1:0];
    assign raddr_o   = sp_m1[AW-1:0];

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_EMPTY;
            sp_q        <= '0;
            overflow_o  <= 1'b0;
            underflow_o <= 1'b0;
        end else begin
            state_q     <= state_n;
            sp_q        <= sp_n;
            overflow_o  <= ovf_n;
            underflow_o <= unf_n;
        end
    end

    // Decode, refusal and next-state process
    always_comb begin
        act_o      = ACT_NONE;
        spill_we_o = 1'b0;
        ovf_n      = 1'b0;
        unf_n      = 1'b0;
        grow       = 1'b0;
        shrink     = 1'b0;
        state_n    = state_q;
        sp_n       = sp_q;

        if (valid_i) begin
            if (opcode_i == OPC_PUSH || opcode_i == OPC_DUP) begin
                if (opcode_i == OPC_DUP && !has_one) begin
                    unf_n = 1'b1;
                end else if (full_o) begin
                    ovf_n = 1'b1;
                end else begin
                    act_o      = (opcode_i == OPC_PUSH) ? ACT_LOAD : ACT_COPY;
                    spill_we_o = has_two;
                    grow       = 1'b1;
                end
            end else if (opcode_i == OPC_DROP) begin
                if (!has_one) begin
                    unf_n = 1'b1;
                end else begin
                    act_o  = ACT_RAISE;
                    shrink = 1'b1;
                end
            end else if (opcode_i == OPC_SWAP) begin
                if (!has_two) unf_n = 1'b1;
                else          act_o = ACT_SWAP;
            end else if (is_binary(opcode_i)) begin
                if (!has_two) begin
                    unf_n = 1'b1;
                end else begin
                    act_o  = ACT_ALU;
                    shrink = 1'b1;
                end
            end
        end

        unique case (state_q)
            ST_EMPTY: begin
                if (grow) state_n = ST_ONE;
            end
            ST_ONE: begin
                if (grow)        state_n = ST_TWO;
                else if (shrink) state_n = ST_EMPTY;
            end
            ST_TWO: begin
                if (grow) begin
                    state_n = ST_DEEP;
                    sp_n    = SPW'(1);
                end else if (shrink) begin
                    state_n = ST_ONE;
                end
            end
            ST_DEEP: begin
                if (grow) begin
                    sp_n = sp_q + SPW'(1);
                end else if (shrink) begin
                    sp_n = sp_m1;
                    if (sp_q == SPW'(1)) state_n = ST_TWO;
                end
            end
        endcase
    end

    a_r8_sp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SPW'(MEM_DEPTH));

    a_r8_sp_only_when_deep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DEEP) |-> (sp_q == '0));

    a_r9_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == OPC_PUSH && full_o)
        |=> (overflow_o && sp_q == $past(sp_q) && state_q == $past(state_q)));

    a_r10_swap_short: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == OPC_SWAP && !has_two) |=> underflow_o);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_o && underflow_o));

endmodule

// File: rtl/stk_cached_top.sv
module stk_cached_top
    import stk_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_DEPTH = 16,
    localparam int AW       = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] tos_o,
    output logic              overflow_o,
    output logic              underflow_o
);

    reg_act_e          act;
    logic              spill_we, fill_ok, full, empty;
    logic [AW-1:0]     waddr, raddr;
    logic [DATA_W-1:0] a_q, b_q;
    logic [DATA_W-1:0] mem_rd, fill_word, alu_y;

    stk_ctrl #(.MEM_DEPTH(MEM_DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .opcode_i    (opcode_i),
        .act_o       (act),
        .spill_we_o  (spill_we),
        .waddr_o     (waddr),
        .raddr_o     (raddr),
        .fill_ok_o   (fill_ok),
        .full_o      (full),
        .empty_o     (empty),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    stk_spill_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (spill_we),
        .waddr_i (waddr),
        .wdata_i (b_q),
        .raddr_i (raddr),
        .rdata_o (mem_rd)
    );

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i     (opcode_i),
        .top_i    (a_q),
        .second_i (b_q),
        .result_o (alu_y)
    );

    // An emptied slot is cleared so the top reads zero on an empty stack
    assign fill_word = fill_ok ? mem_rd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            unique case (act)
                ACT_NONE:  ;
                ACT_LOAD:  begin a_q <= push_data_i; b_q <= a_q;       end
                ACT_COPY:  b_q <= a_q;
                ACT_RAISE: begin a_q <= b_q;         b_q <= fill_word; end
                ACT_SWAP:  begin a_q <= b_q;         b_q <= a_q;       end
                ACT_ALU:   begin a_q <= alu_y;       b_q <= fill_word; end
                default:   ;
            endcase
        end
    end

    assign tos_o = a_q;

    a_r1_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (a_q == '0 && b_q == '0));

    a_r2_push_lands_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == OPC_PUSH && !full)
        |=> (tos_o == $past(push_data_i) && b_q == $past(a_q)));

    a_r5_swap_exchanges: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SWAP) |=> (a_q == $past(b_q) && b_q == $past(a_q)));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: tb/stk_cached_top_bench.sv
module stk_cached_top_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW  = 8;
    localparam int MD  = 4;
    localparam int CAP = MD + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [3:0]    opcode_i = 4'd0;
    logic [DW-1:0] push_data_i = '0;
    logic [DW-1:0] tos_o;
    logic          overflow_o, underflow_o;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mdl [CAP];
    int            mcnt = 0;
    logic          e_ovf, e_unf;

    always #2.5 clk = ~clk;

    stk_cached_top #(.DATA_W(DW), .MEM_DEPTH(MD)) u_stk_cached_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .opcode_i    (opcode_i),
        .push_data_i (push_data_i),
        .tos_o       (tos_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_tos();
        return (mcnt > 0) ? mdl[mcnt-1] : '0;
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic v);
        if (e_ovf) return "R9";
        if (e_unf) return "R10";
        if (!v) return "R11";
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R6";
            default: return "R11";
        endcase
    endfunction

    // Reference model of the stack contents
    task automatic model(input logic v, input logic [3:0] op, input logic [DW-1:0] d);
        logic [DW-1:0] t, s, r;
        e_ovf = 1'b0;
        e_unf = 1'b0;
        if (!v) return;
        case (op)
            4'd1: if (mcnt == CAP) e_ovf = 1'b1;
                  else begin mdl[mcnt] = d; mcnt++; end
            4'd3: if (mcnt == 0) e_unf = 1'b1;
                  else if (mcnt == CAP) e_ovf = 1'b1;
                  else begin mdl[mcnt] = mdl[mcnt-1]; mcnt++; end
            4'd2: if (mcnt == 0) e_unf = 1'b1; else mcnt--;
            4'd4: if (mcnt < 2) e_unf = 1'b1;
                  else begin t = mdl[mcnt-1]; mdl[mcnt-1] = mdl[mcnt-2]; mdl[mcnt-2] = t; end
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
                if (mcnt < 2) e_unf = 1'b1;
                else begin
                    t = mdl[mcnt-1];
                    s = mdl[mcnt-2];
                    case (op)
                        4'd5: r = s + t;
                        4'd6: r = s - t;
                        4'd7: r = s & t;
                        4'd8: r = s | t;
                        default: r = s ^ t;
                    endcase
                    mcnt--;
                    mdl[mcnt-1] = r;
                end
            end
            default: ;
        endcase
    endtask

    // Present one operation at a falling edge, sample at the next falling edge
    task automatic step(input logic v, input logic [3:0] op, input logic [DW-1:0] d,
                        input bit check_it);
        string tg;
        valid_i     = v;
        opcode_i    = op;
        push_data_i = d;
        model(v, op, d);
        @(negedge clk);
        if (check_it) begin
            tg = tag_of(op, v);
            chk(tg, "tos", tos_o, exp_tos());
            chk(tg, "overflow", {{(DW-1){1'b0}}, overflow_o}, {{(DW-1){1'b0}}, e_ovf});
            chk(tg, "underflow", {{(DW-1){1'b0}}, underflow_o}, {{(DW-1){1'b0}}, e_unf});
        end
    endtask

    task automatic idle();
        valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        valid_i = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mcnt  = 0;
        @(negedge clk);
    endtask

    // R8: empty the stack, checking LIFO order through the memory boundary
    task automatic drain();
        int n;
        n = mcnt;
        for (int i = 0; i < n; i++) begin
            chk("R8", "drain order", tos_o, exp_tos());
            step(1'b1, 4'd2, '0, 1'b0);
        end
        chk("R3", "empty reads zero", tos_o, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1", "tos after reset", tos_o, '0);
        chk("R1", "flags after reset", {6'd0, overflow_o, underflow_o}, '0);

        // Every opcode at every fill level, with and without valid
        for (int lvl = 0; lvl <= CAP; lvl++) begin
            for (int op = 0; op < 16; op++) begin
                for (int v = 0; v < 2; v++) begin
                    if (v == 0 && op != 1) continue;
                    do_reset();
                    for (int k = 0; k < lvl; k++)
                        step(1'b1, 4'd1, DW'(8'h11 * (k + 1) + lvl), 1'b0);
                    step(v[0], op[3:0], DW'(8'hA5 ^ op), 1'b1);
                    idle();
                    chk("R9", "overflow pulse ends", {7'd0, overflow_o}, '0);
                    chk("R10", "underflow pulse ends", {7'd0, underflow_o}, '0);
                    drain();
                end
            end
        end

        // R6: operand grid on a full stack, then check the refilled third entry
        do_reset();
        step(1'b1, 4'd1, 8'h3C, 1'b0);
        step(1'b1, 4'd1, 8'h5A, 1'b0);
        step(1'b1, 4'd1, 8'h77, 1'b0);
        step(1'b1, 4'd1, 8'h81, 1'b0);
        for (int op = 5; op <= 9; op++) begin
            for (int a = 0; a < 256; a += 17) begin
                for (int b = 0; b < 256; b += 13) begin
                    logic [DW-1:0] av, bv, rv;
                    av = DW'(a);
                    bv = DW'(b);
                    case (op)
                        5: rv = DW'((b + a) % 256);
                        6: rv = DW'((b - a + 256) % 256);
                        7: rv = bv & av;
                        8: rv = bv | av;
                        default: rv = bv ^ av;
                    endcase
                    step(1'b1, 4'd1, bv, 1'b0);
                    step(1'b1, 4'd1, av, 1'b0);
                    step(1'b1, op[3:0], '0, 1'b0);
                    chk("R6", "binary result", tos_o, rv);
                    step(1'b1, 4'd2, '0, 1'b0);
                    chk("R6", "third entry refilled", tos_o, 8'h81);
                end
            end
        end
        drain();

        // R7: back-to-back operations, one per cycle, no idle between
        do_reset();
        for (int k = 0; k < CAP; k++)
            step(1'b1, 4'd1, DW'(k * 29 + 3), 1'b1);
        step(1'b1, 4'd4, '0, 1'b1);
        step(1'b1, 4'd6, '0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 4'd5, '0, 1'b0);
            chk("R7", "consecutive ALU", tos_o, exp_tos());
        end
        step(1'b1, 4'd3, '0, 1'b1);
        step(1'b1, 4'd9, '0, 1'b1);
        idle();
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule